// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches a group of digital input pins and raises a sticky interrupt request when any pin that software has armed changes level. It keeps a per-pin reference copy of the levels that software last read. Any armed pin whose synchronized level no longer matches that copy sets the interrupt flag. A register read port and a register write port give access to two words of arm bits and two words of pull-up request bits. The pull-up request for a pin leaves the block only while that pin is configured as an input.

When the sleep input is high, the sampling pipeline and the reference copy stop updating, in the same way they would if their clock were stopped. A purely combinational compare of the raw armed pins against the held reference copy drives a wake request. The wake request lets the system restart its clocks. Once sleep falls, the pipeline resumes, sees the changed pin and sets the interrupt flag, so a change made during sleep is not lost.

Top module: `pin_change_notifier`

## Requirements
- R1: After reset, every arm bit and pull-up bit is 0, `changeIrq` is 0, `pullEn` is all zeros, `portData` is all zeros and the reference copy is all zeros.
- R2: Register map. Address 0 holds the arm bits of pins 0 to 15 and address 1 holds the arm bits of pins 16 to 30. Address 2 holds the pull-up bits of pins 0 to 15 and address 3 holds the pull-up bits of pins 16 to 30. Bit n of a word maps to pin 16*k+n. Bit 15 of addresses 1 and 3 ignores writes and reads as 0. `regRdData` shows the word at `regAddr` combinationally, and a write takes effect at the clock edge where `regWrEn` is high.
- R3: While awake, a level change on an armed pin that is present before clock edge k makes `changeIrq` high after edge k+2, because the pin passes through two synchronizer stages.
- R4: A change on a pin whose arm bit is 0 never sets `changeIrq`. Clearing an arm bit masks a pending mismatch on that pin but leaves its reference copy unchanged, so setting the bit again sets the flag at the next edge.
- R5: `changeIrq` stays high until a `flagClr` pulse arrives in a cycle with no armed mismatch. When a mismatch is present, setting the flag wins over clearing it.
- R6: `portData` shows the synchronized pin levels. A `portRead` pulse copies `portData` into the reference copy at the next edge.
- R7: `pullEn[i]` is the pull-up bit of pin i ANDed with `pinDir[i]`, where a `pinDir` value of 1 means input and 0 means output.
- R8: While `sleep` is high, the synchronizers and the reference copy hold their values. `wakeReq` is high exactly when `sleep` is high and some armed raw pin differs from its reference copy. `wakeReq` is 0 whenever `sleep` is low.
- R9: A change made during sleep on an armed pin sets `changeIrq` after the third clock edge that follows the fall of `sleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | High while the system sleeps; freezes sampling |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` |
| flagClr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| portRead | input | 1 | Port read pulse; refreshes the reference copy |
| pinIn | input | 31 | Raw asynchronous pin levels |
| pinDir | input | 31 | Pin direction, 1 = input |
| portData | output | 31 | Synchronized pin levels |
| pullEn | output | 31 | Pull-up enables, gated by direction |
| changeIrq | output | 1 | Sticky change interrupt request |
| wakeReq | output | 1 | Combinational wake request during sleep |

## Verification
The assertions assume that `sleep` is a level that changes only between clock edges. They also assume that software clears the flag and refreshes the copy only through single-cycle `flagClr` and `portRead` pulses. The stimulus drives all inputs at the falling edge, including the raw pins, so the synchronizers always capture settled values. Sleep windows are entered and left at falling edges, with pins changing while asleep. Random phases mix register writes, direction changes, clears and port reads, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/pcn_pkg.sv
package pcn_pkg;
  localparam int REG_W = 16;

  typedef struct packed {
    logic sampleEn;
    logic snapLoad;
  } pcnStrobes_t;
endpackage

// File: rtl/pcn_control.sv
module pcn_control
  import pcn_pkg::*;
#(
  parameter int PIN_COUNT = 31,
  localparam int WORDS = (PIN_COUNT + REG_W - 1) / REG_W,
  localparam int TOTAL_BITS = WORDS * REG_W,
  localparam int ADDR_W = $clog2(2 * WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sleep,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  input  logic                 flagClr,
  input  logic                 portRead,
  input  logic                 anyMismatch,
  output pcnStrobes_t          strobes,
  output logic [PIN_COUNT-1:0] armVec,
  output logic [PIN_COUNT-1:0] pullVec,
  output logic [REG_W-1:0]     regRdData,
  output logic                 changeIrq
);
  localparam logic [TOTAL_BITS-1:0] VALID_MASK =
    TOTAL_BITS'((64'd1 << PIN_COUNT) - 64'd1);

  logic [TOTAL_BITS-1:0] armStore;
  logic [TOTAL_BITS-1:0] pullStore;
  logic                  irqFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armStore  <= '0;
      pullStore <= '0;
    end else if (regWrEn) begin
      for (int w = 0; w < WORDS; w++) begin
        if (regAddr == ADDR_W'(w))
          armStore[w*REG_W +: REG_W] <= regWrData & VALID_MASK[w*REG_W +: REG_W];
        if (regAddr == ADDR_W'(w + WORDS))
          pullStore[w*REG_W +: REG_W] <= regWrData & VALID_MASK[w*REG_W +: REG_W];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (regAddr == ADDR_W'(w))         regRdData = armStore[w*REG_W +: REG_W];
      if (regAddr == ADDR_W'(w + WORDS)) regRdData = pullStore[w*REG_W +: REG_W];
    end
  end

  // set has priority so that a change seen in the clearing cycle survives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqFlag <= 1'b0;
    else       irqFlag <= anyMismatch | (irqFlag & ~flagClr);
  end

  always_comb begin
    strobes.sampleEn = ~sleep;
    strobes.snapLoad = portRead & ~sleep;
  end

  assign armVec    = armStore[PIN_COUNT-1:0];
  assign pullVec   = pullStore[PIN_COUNT-1:0];
  assign changeIrq = irqFlag;
endmodule

// File: rtl/pcn_datapath.sv
module pcn_datapath
  import pcn_pkg::*;
#(
  parameter int PIN_COUNT = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pcnStrobes_t          strobes,
  input  logic                 sleep,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] pinDir,
  input  logic [PIN_COUNT-1:0] armVec,
  input  logic [PIN_COUNT-1:0] pullVec,
  output logic [PIN_COUNT-1:0] portData,
  output logic [PIN_COUNT-1:0] pullEn,
  output logic                 anyMismatch,
  output logic                 wakeReq
);
  logic [PIN_COUNT-1:0] syncStage [SYNC_STAGES];
  logic [PIN_COUNT-1:0] snapshot;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 syncStage[s] <= '0;
      else if (strobes.sampleEn) syncStage[s] <= (s == 0) ? pinIn : syncStage[(s == 0) ? 0 : s - 1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 snapshot <= '0;
    else if (strobes.snapLoad) snapshot <= syncStage[SYNC_STAGES-1];
  end

  assign portData    = syncStage[SYNC_STAGES-1];
  assign anyMismatch = |(armVec & (portData ^ snapshot));
  // raw path: must work with the sampling clock stopped
  assign wakeReq     = sleep & (|(armVec & (pinIn ^ snapshot)));

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pull
    assign pullEn[i] = pullVec[i] & pinDir[i];
  end
endmodule

// File: rtl/pin_change_notifier.sv
module pin_change_notifier
  import pcn_pkg::*;
#(
  parameter int PIN_COUNT = 31,
  localparam int WORDS = (PIN_COUNT + REG_W - 1) / REG_W,
  localparam int ADDR_W = $clog2(2 * WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sleep,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 flagClr,
  input  logic                 portRead,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] pinDir,
  output logic [PIN_COUNT-1:0] portData,
  output logic [PIN_COUNT-1:0] pullEn,
  output logic                 changeIrq,
  output logic                 wakeReq
);
  pcnStrobes_t          strobes;
  logic [PIN_COUNT-1:0] armVec;
  logic [PIN_COUNT-1:0] pullVec;
  logic                 anyMismatch;

  pcn_control #(.PIN_COUNT(PIN_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .sleep(sleep),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .flagClr(flagClr), .portRead(portRead), .anyMismatch(anyMismatch),
    .strobes(strobes), .armVec(armVec), .pullVec(pullVec),
    .regRdData(regRdData), .changeIrq(changeIrq)
  );

  pcn_datapath #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sleep(sleep),
    .pinIn(pinIn), .pinDir(pinDir), .armVec(armVec), .pullVec(pullVec),
    .portData(portData), .pullEn(pullEn), .anyMismatch(anyMismatch),
    .wakeReq(wakeReq)
  );
endmodule

// File: rtl/pcn_checker.sv
module pcn_checker
  import pcn_pkg::*;
#(
  parameter int PIN_COUNT = 31,
  localparam int WORDS = (PIN_COUNT + REG_W - 1) / REG_W,
  localparam int ADDR_W = $clog2(2 * WORDS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sleep,
  input logic                 flagClr,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [REG_W-1:0]     regRdData,
  input logic [PIN_COUNT-1:0] pinDir,
  input logic [PIN_COUNT-1:0] portData,
  input logic [PIN_COUNT-1:0] pullEn,
  input logic                 changeIrq,
  input logic                 wakeReq
);
  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (changeIrq && !flagClr) |=> changeIrq);

  p_pull_output_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pullEn & ~pinDir) == '0);

  p_wake_needs_sleep_r8: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> sleep);

  p_sample_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> $stable(portData));

  if (PIN_COUNT == 31) begin : g_rsv
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
      regAddr[0] |-> !regRdData[15]);
  end
endmodule

bind pin_change_notifier pcn_checker #(.PIN_COUNT(PIN_COUNT)) u_chk (
  .clk(clk), .rstN(rstN), .sleep(sleep), .flagClr(flagClr),
  .regAddr(regAddr), .regRdData(regRdData), .pinDir(pinDir),
  .portData(portData), .pullEn(pullEn), .changeIrq(changeIrq),
  .wakeReq(wakeReq)
);

// File: tb/sim_pin_change_notifier.sv
`timescale 1ns/1ps
module sim_pin_change_notifier;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sleep = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        flagClr = 1'b0;
  logic        portRead = 1'b0;
  logic [30:0] pinIn = '0;
  logic [30:0] pinDir = '0;
  logic [30:0] portData;
  logic [30:0] pullEn;
  logic        changeIrq;
  logic        wakeReq;

  always #4 clk = ~clk;

  pin_change_notifier u0 (
    .clk(clk), .rstN(rstN), .sleep(sleep), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .flagClr(flagClr), .portRead(portRead), .pinIn(pinIn), .pinDir(pinDir),
    .portData(portData), .pullEn(pullEn), .changeIrq(changeIrq),
    .wakeReq(wakeReq)
  );

  int  nChecks = 0;
  int  nErrors = 0;
  bit  finished = 1'b0;

  // behavioural reference model
  logic [30:0] mStage1, mStage2, mCopy, mArm, mPull;
  logic        mFlag;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStage1 <= '0; mStage2 <= '0; mCopy <= '0;
      mArm <= '0; mPull <= '0; mFlag <= 1'b0;
    end else begin
      if (!sleep) begin
        mStage1 <= pinIn;
        mStage2 <= mStage1;
        if (portRead) mCopy <= mStage2;
      end
      mFlag <= ((mArm & (mStage2 ^ mCopy)) != 0) || (mFlag && !flagClr);
      if (regWrEn) begin
        case (regAddr)
          2'd0: mArm[15:0]   <= regWrData;
          2'd1: mArm[30:16]  <= regWrData[14:0];
          2'd2: mPull[15:0]  <= regWrData;
          default: mPull[30:16] <= regWrData[14:0];
        endcase
      end
    end
  end

  function automatic logic [15:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return mArm[15:0];
      2'd1: return {1'b0, mArm[30:16]};
      2'd2: return mPull[15:0];
      default: return {1'b0, mPull[30:16]};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R3 model changeIrq", 32'(changeIrq), 32'(mFlag));
      check("R8 model wakeReq", 32'(wakeReq),
            32'(sleep && ((mArm & (pinIn ^ mCopy)) != 0)));
      check("R7 model pullEn", 32'(pullEn), 32'(mPull & pinDir));
      check("R6 model portData", 32'(portData), 32'(mStage2));
      check("R2 model regRdData", 32'(regRdData), 32'(modelRead(regAddr)));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic pulseClr();
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
  endtask

  task automatic pulseRead();
    portRead = 1'b1; tick(1); portRead = 1'b0;
  endtask

  task automatic report();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 irq after reset", 32'(changeIrq), 0);
    check("R1 pullEn after reset", 32'(pullEn), 0);
    check("R1 portData after reset", 32'(portData), 0);
    for (int a = 0; a < 4; a++) begin
      regAddr = 2'(a); #1;
      check("R1 register zero after reset", 32'(regRdData), 0);
    end

    // R2 register map and reserved bit
    writeReg(2'd0, 16'h00FF);
    writeReg(2'd1, 16'hFFFF);
    writeReg(2'd2, 16'hFFFF);
    writeReg(2'd3, 16'hFFFF);
    regAddr = 2'd1; #1;
    check("R2 arm hi reserved bit", 32'(regRdData), 32'h7FFF);
    regAddr = 2'd3; #1;
    check("R2 pull hi reserved bit", 32'(regRdData), 32'h7FFF);
    regAddr = 2'd0; #1;
    check("R2 arm lo", 32'(regRdData), 32'h00FF);

    // R7 direction gating
    pinDir = 31'h0F0F_0F0F; #1;
    check("R7 pullEn gated", 32'(pullEn), 32'h0F0F_0F0F);
    pinDir = 31'h7FFF_FFFF;
    tick(1);

    // R3 latency on armed pin 3
    pinIn[3] = 1'b1;
    tick(2);
    check("R3 irq not yet", 32'(changeIrq), 0);
    tick(1);
    check("R3 irq raised", 32'(changeIrq), 1);

    // R5 clear while mismatch persists
    pulseClr();
    check("R5 set wins over clear", 32'(changeIrq), 1);
    pulseRead();
    tick(1);
    pulseClr();
    check("R5 cleared after refresh", 32'(changeIrq), 0);
    check("R6 portData shows pin", 32'(portData[3]), 1);

    // R4 unarmed pin ignored, then masked mismatch revealed
    pinIn[10] = 1'b1;
    tick(5);
    check("R4 unarmed pin ignored", 32'(changeIrq), 0);
    writeReg(2'd0, 16'h04FF);
    tick(1);
    check("R4 re-arm exposes held mismatch", 32'(changeIrq), 1);
    writeReg(2'd0, 16'h00FF);
    pulseClr();
    tick(1);
    check("R4 disarm masks mismatch", 32'(changeIrq), 0);
    pulseRead();

    // R8 / R9 sleep
    tick(2);
    sleep = 1'b1;
    pinIn[20] = 1'b1;
    tick(1);
    check("R8 wake during sleep", 32'(wakeReq), 1);
    check("R8 portData frozen", 32'(portData[20]), 0);
    tick(4);
    check("R8 irq frozen asleep", 32'(changeIrq), 0);
    sleep = 1'b0; #1;
    check("R8 wake low when awake", 32'(wakeReq), 0);
    tick(2);
    check("R9 irq not yet after wake", 32'(changeIrq), 0);
    tick(1);
    check("R9 irq after wake", 32'(changeIrq), 1);
    pulseRead();
    tick(1);
    pulseClr();

    // random phase, model compared every cycle
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8)       pinIn = pinIn ^ (31'd1 << $urandom_range(0, 30));
      if (r == 9)      pinDir = 31'($urandom());
      if (r == 10)     begin regWrEn = 1'b1; regWrData = 16'($urandom()); end
      else             regWrEn = 1'b0;
      regAddr  = 2'($urandom_range(0, 3));
      flagClr  = (r > 90);
      portRead = (r > 85 && r < 90);
      if (r == 11) sleep = ~sleep;
      tick(1);
    end
    sleep = 1'b0; flagClr = 1'b0; portRead = 1'b0; regWrEn = 1'b0;
    tick(2);
    report();
  end
endmodule